// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block watches the decoded command stream of a DDR2 memory bus and reports any command that arrives too soon after an earlier command it conflicts with. It keeps a saturating "cycles since" counter for each bank and each event type: activate, read, write and precharge. It also keeps bus-wide counters for activates, column commands, reads and writes. Each incoming command is compared against minimum gaps built from the timing parameters. The read/write turnaround limits are derived from the latency terms and the half-burst length. They are not taken as fixed constants.

Read latency is the sum of the additive latency and the CAS latency. Write latency is one less than read latency. Both values are derived at elaboration. When a command breaks one or more rules, the monitor raises a one-cycle violation pulse together with a code that names the rule. If several rules are broken, the lowest code wins. The monitor never alters the bus. It is meant to sit beside a controller or a command generator during integration.

Top module: `ddr2_spacing_mon`

## Requirements
- R1: A read (cmd 2) or write (cmd 3) to a bank fewer than T_RCD cycles after that bank's activate (cmd 1) is flagged with code 1.
- R2: An activate fewer than T_RRD cycles after the previous activate to any bank is flagged with code 2.
- R3: A read or write fewer than T_CCD cycles after the previous read or write to any bank is flagged with code 3.
- R4: A read fewer than WL + BL/2 + T_WTR cycles after the last write to any bank is flagged with code 4.
- R5: A write fewer than RL + BL/2 - WL cycles after the last read to any bank is flagged with code 5.
- R6: A precharge (cmd 4, one bank) or precharge-all (cmd 5, bank input ignored) fewer than AL + BL/2 + T_RTP - 2 cycles after a read to a covered bank is flagged with code 6.
- R7: A precharge or precharge-all fewer than WL + BL/2 + T_WR cycles after a write to a covered bank is flagged with code 7.
- R8: An activate to a bank fewer than T_RP cycles after a precharge or precharge-all that covered it is flagged with code 8.
- R9: When several rules fail for one command, the smallest code among them is reported.
- R10: The violation output is high for exactly one cycle, in the cycle after the offending command is sampled. The code is nonzero exactly when the violation output is high, and zero otherwise.
- R11: A no-operation (cmd 0) or an unused encoding (cmd 6 or 7) never raises a violation.
- R12: History counters saturate, so a command issued after an idle period of any length is not flagged against events that are older than every limit.
- R13: After reset no past events are assumed, and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all |
| bank | input | BANK_W | Bank address of the command |
| viol | output | 1 | One-cycle pulse marking a spacing violation |
| viol_code | output | 4 | Broken rule (1..8), zero when no violation |

## Verification
The hardest case to reach is a command that fails several rules at once, because the priority ordering only shows up then. An example is a read that is both too close to its bank's activate and too close to a read on another bank. Directed sequences line these collisions up, along with exact-boundary gaps and a long idle run that forces every counter into saturation. A pseudo-random command stream is then compared on every clock against a behavioural model that stores event times as integers. At the end, the bench confirms that every violation code was produced at least once.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE = 4'd0,
    V_RCD  = 4'd1,
    V_RRD  = 4'd2,
    V_CCD  = 4'd3,
    V_WTR  = 4'd4,
    V_RTW  = 4'd5,
    V_RTP  = 4'd6,
    V_WRP  = 4'd7,
    V_RP   = 4'd8
  } vcode_e;

  function automatic int clamp0(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_gap_cnt.sv
// Saturating "cycles since last event" counter; resets to saturation (no history).
module ddr2_gap_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != CMAX);
    cnt_d  = start ? CW'(1) : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CMAX;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !start) |=> (cnt_q == CMAX));

  // R8
  start_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/ddr2_rule_eval.sv
// Combinational rule check; lowest-numbered failing rule is selected.
module ddr2_rule_eval
  import ddr2_mon_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int CW     = 5,
  parameter int L_RCD  = 4,
  parameter int L_RRD  = 2,
  parameter int L_CCD  = 2,
  parameter int L_WTR  = 9,
  parameter int L_RTW  = 5,
  parameter int L_RTP  = 4,
  parameter int L_WRP  = 11,
  parameter int L_RP   = 4
) (
  input  cmd_e                     cmd,
  input  logic [BANK_W-1:0]        bank,
  input  logic [NB-1:0][CW-1:0]    b_act,
  input  logic [NB-1:0][CW-1:0]    b_rd,
  input  logic [NB-1:0][CW-1:0]    b_wr,
  input  logic [NB-1:0][CW-1:0]    b_pre,
  input  logic [CW-1:0]            g_act,
  input  logic [CW-1:0]            g_col,
  input  logic [CW-1:0]            g_rd,
  input  logic [CW-1:0]            g_wr,
  output vcode_e                   code
);
  localparam logic [CW-1:0] C_RCD = CW'(L_RCD);
  localparam logic [CW-1:0] C_RRD = CW'(L_RRD);
  localparam logic [CW-1:0] C_CCD = CW'(L_CCD);
  localparam logic [CW-1:0] C_WTR = CW'(L_WTR);
  localparam logic [CW-1:0] C_RTW = CW'(L_RTW);
  localparam logic [CW-1:0] C_RTP = CW'(L_RTP);
  localparam logic [CW-1:0] C_WRP = CW'(L_WRP);
  localparam logic [CW-1:0] C_RP  = CW'(L_RP);

  logic [NB-1:0] rtp_b, wrp_b, sel;
  logic          is_col, is_pre, rtp_hit, wrp_hit;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign rtp_b[b] = (b_rd[b] < C_RTP);
    assign wrp_b[b] = (b_wr[b] < C_WRP);
    assign sel[b]   = (cmd == CMD_PREA) || (bank == BANK_W'(b));
  end

  always_comb begin
    is_col  = (cmd == CMD_RD) || (cmd == CMD_WR);
    is_pre  = (cmd == CMD_PRE) || (cmd == CMD_PREA);
    rtp_hit = |(rtp_b & sel);
    wrp_hit = |(wrp_b & sel);
    code    = V_NONE;
    if      (is_col && (b_act[bank] < C_RCD))        code = V_RCD;
    else if ((cmd == CMD_ACT) && (g_act < C_RRD))    code = V_RRD;
    else if (is_col && (g_col < C_CCD))              code = V_CCD;
    else if ((cmd == CMD_RD) && (g_wr < C_WTR))      code = V_WTR;
    else if ((cmd == CMD_WR) && (g_rd < C_RTW))      code = V_RTW;
    else if (is_pre && rtp_hit)                      code = V_RTP;
    else if (is_pre && wrp_hit)                      code = V_WRP;
    else if ((cmd == CMD_ACT) && (b_pre[bank] < C_RP)) code = V_RP;
  end

endmodule

// File: rtl/ddr2_spacing_mon.sv
module ddr2_spacing_mon
  import ddr2_mon_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int CL     = 4,
  parameter int AL     = 0,
  parameter int BL     = 8,
  parameter int T_RCD  = 4,
  parameter int T_RP   = 4,
  parameter int T_RRD  = 2,
  parameter int T_CCD  = 2,
  parameter int T_WTR  = 2,
  parameter int T_WR   = 4,
  parameter int T_RTP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  output logic              viol,
  output logic [3:0]        viol_code
);
  localparam int RL    = AL + CL;
  localparam int WL    = RL - 1;
  localparam int HB    = BL / 2;
  localparam int L_RCD = clamp0(T_RCD);
  localparam int L_RRD = clamp0(T_RRD);
  localparam int L_CCD = clamp0(T_CCD);
  localparam int L_WTR = clamp0(WL + HB + T_WTR);
  localparam int L_RTW = clamp0(RL + HB - WL);
  localparam int L_RTP = clamp0(AL + HB + T_RTP - 2);
  localparam int L_WRP = clamp0(WL + HB + T_WR);
  localparam int L_RP  = clamp0(T_RP);
  localparam int L_MAX = imax(imax(imax(L_RCD, L_RRD), imax(L_CCD, L_WTR)),
                              imax(imax(L_RTW, L_RTP), imax(L_WRP, L_RP)));
  localparam int CW    = $clog2(L_MAX + 1) + 1;

  cmd_e cmd_t;
  assign cmd_t = cmd_e'(cmd);

  logic [NB-1:0][CW-1:0] b_act, b_rd, b_wr, b_pre;
  logic [CW-1:0]         g_act, g_col, g_rd, g_wr;

  for (genvar b = 0; b < NB; b++) begin : g_bank_cnt
    logic hit;
    assign hit = (bank == BANK_W'(b));
    ddr2_gap_cnt #(.CW(CW)) u_act (.clk(clk), .rst_n(rst_n),
      .start(hit && cmd_t == CMD_ACT), .cnt(b_act[b]));
    ddr2_gap_cnt #(.CW(CW)) u_rd  (.clk(clk), .rst_n(rst_n),
      .start(hit && cmd_t == CMD_RD), .cnt(b_rd[b]));
    ddr2_gap_cnt #(.CW(CW)) u_wr  (.clk(clk), .rst_n(rst_n),
      .start(hit && cmd_t == CMD_WR), .cnt(b_wr[b]));
    ddr2_gap_cnt #(.CW(CW)) u_pre (.clk(clk), .rst_n(rst_n),
      .start((hit && cmd_t == CMD_PRE) || cmd_t == CMD_PREA), .cnt(b_pre[b]));
  end

  ddr2_gap_cnt #(.CW(CW)) u_g_act (.clk(clk), .rst_n(rst_n),
    .start(cmd_t == CMD_ACT), .cnt(g_act));
  ddr2_gap_cnt #(.CW(CW)) u_g_col (.clk(clk), .rst_n(rst_n),
    .start(cmd_t == CMD_RD || cmd_t == CMD_WR), .cnt(g_col));
  ddr2_gap_cnt #(.CW(CW)) u_g_rd  (.clk(clk), .rst_n(rst_n),
    .start(cmd_t == CMD_RD), .cnt(g_rd));
  ddr2_gap_cnt #(.CW(CW)) u_g_wr  (.clk(clk), .rst_n(rst_n),
    .start(cmd_t == CMD_WR), .cnt(g_wr));

  vcode_e code_w;

  ddr2_rule_eval #(
    .NB(NB), .BANK_W(BANK_W), .CW(CW),
    .L_RCD(L_RCD), .L_RRD(L_RRD), .L_CCD(L_CCD), .L_WTR(L_WTR),
    .L_RTW(L_RTW), .L_RTP(L_RTP), .L_WRP(L_WRP), .L_RP(L_RP)
  ) u_eval (
    .cmd(cmd_t), .bank(bank),
    .b_act(b_act), .b_rd(b_rd), .b_wr(b_wr), .b_pre(b_pre),
    .g_act(g_act), .g_col(g_col), .g_rd(g_rd), .g_wr(g_wr),
    .code(code_w)
  );

  logic       viol_q, viol_d;
  logic [3:0] code_q, code_d;

  always_comb begin
    code_d = code_w;
    viol_d = (code_w != V_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      code_q <= 4'd0;
    end else begin
      viol_q <= viol_d;
      code_q <= code_d;
    end
  end

  assign viol      = viol_q;
  assign viol_code = code_q;

  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> (code_q >= 4'd1 && code_q <= 4'd8));

  // R10
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_q |-> (code_q == 4'd0));

  // R11
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) |=> !viol_q);

  // R1
  rcd_col_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_w == V_RCD) |-> (cmd == 3'd2 || cmd == 3'd3));

  // R8
  rp_act_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_w == V_RP) |-> (cmd == 3'd1));

endmodule

// File: tb/test_ddr2_spacing_mon.sv
module test_ddr2_spacing_mon;
  localparam int CL = 4, AL = 0, BL = 8;
  localparam int T_RCD = 4, T_RP = 4, T_RRD = 2, T_CCD = 2;
  localparam int T_WTR = 2, T_WR = 4, T_RTP = 2;
  localparam int RL = AL + CL, WL = RL - 1;
  localparam int NEVER = -1000000;

  logic       clk, rst_n;
  logic [2:0] cmd;
  logic [1:0] bank;
  logic       viol;
  logic [3:0] viol_code;

  int checks = 0, errors = 0, cyc = 0;
  int t_act[4], t_rd[4], t_wr[4], t_pre[4];
  int g_act, g_col, g_rd, g_wr;
  int seen[9];
  int lcg = 12345;

  ddr2_spacing_mon #(
    .NB(4), .BANK_W(2), .CL(CL), .AL(AL), .BL(BL), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RRD(T_RRD), .T_CCD(T_CCD), .T_WTR(T_WTR), .T_WR(T_WR), .T_RTP(T_RTP)
  ) i_ddr2_spacing_mon (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
    .viol(viol), .viol_code(viol_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string rtag(input int c);
    case (c)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Behavioural expectation: lowest failing rule number (R9).
  function automatic int expect_code(input int c, input int b);
    bit col = (c == 2 || c == 3);
    bit pre = (c == 4 || c == 5);
    bit rtp = 0, wrp = 0;
    for (int k = 0; k < 4; k++) begin
      if (c == 5 || k == b) begin
        if (cyc - t_rd[k] < AL + BL/2 + T_RTP - 2) rtp = 1;
        if (cyc - t_wr[k] < WL + BL/2 + T_WR) wrp = 1;
      end
    end
    if (col && cyc - t_act[b] < T_RCD)                 return 1;
    if (c == 1 && cyc - g_act < T_RRD)                 return 2;
    if (col && cyc - g_col < T_CCD)                    return 3;
    if (c == 2 && cyc - g_wr < WL + BL/2 + T_WTR)      return 4;
    if (c == 3 && cyc - g_rd < RL + BL/2 - WL)         return 5;
    if (pre && rtp)                                    return 6;
    if (pre && wrp)                                    return 7;
    if (c == 1 && cyc - t_pre[b] < T_RP)               return 8;
    return 0;
  endfunction

  task automatic model_update(input int c, input int b);
    case (c)
      1: begin t_act[b] = cyc; g_act = cyc; end
      2: begin t_rd[b] = cyc; g_rd = cyc; g_col = cyc; end
      3: begin t_wr[b] = cyc; g_wr = cyc; g_col = cyc; end
      4: t_pre[b] = cyc;
      5: for (int k = 0; k < 4; k++) t_pre[k] = cyc;
      default: ;
    endcase
  endtask

  task automatic check_out(input int exp, input string tag);
    checks++;
    if (viol !== (exp != 0) || viol_code !== 4'(exp)) begin
      errors++;
      $display("FAIL %s cycle %0d: viol=%0b code=%0d expected viol=%0b code=%0d",
               tag, cyc, viol, viol_code, (exp != 0), exp);
    end
  endtask

  // Drive one command at a negedge, compare one cycle later (R10).
  task automatic step(input int c, input int b);
    int e;
    cmd  = 3'(c);
    bank = 2'(b);
    e = expect_code(c, b);
    model_update(c, b);
    seen[e]++;
    cyc++;
    @(negedge clk);
    check_out(e, (e == 0) ? ((c == 0 || c > 5) ? "R11" : "R12") : rtag(e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      t_act[k] = NEVER; t_rd[k] = NEVER; t_wr[k] = NEVER; t_pre[k] = NEVER;
    end
    g_act = NEVER; g_col = NEVER; g_rd = NEVER; g_wr = NEVER;
    for (int k = 0; k < 9; k++) seen[k] = 0;
    rst_n = 1'b0; cmd = 3'd0; bank = 2'd0;
    repeat (3) @(negedge clk);
    check_out(0, "R13");
    rst_n = 1'b1;
    @(negedge clk);
    check_out(0, "R13");

    step(1, 0); step(2, 0);                       // R1 gap 1 < tRCD
    idle(10); step(1, 1); step(1, 2);             // R2
    idle(10); step(2, 1); step(2, 2);             // R3
    idle(10); step(3, 0); idle(2); step(2, 1);    // R4
    idle(12); step(2, 0); idle(1); step(3, 1);    // R5
    idle(20); step(2, 0); step(4, 0);             // R6
    idle(20); step(3, 1); idle(1); step(5, 3);    // R7 through precharge-all
    step(1, 0);                                   // R8
    idle(20); step(1, 2); idle(1); step(2, 0); step(2, 2); // R9: RCD and CCD, RCD wins
    idle(20); step(1, 3); idle(T_RCD - 1); step(2, 3);     // R1 exact boundary, clean
    idle(20); step(3, 3); idle(WL + BL/2 + T_WR - 1); step(4, 3); // R7 boundary, clean
    step(6, 1); step(7, 2);                       // R11 unused encodings
    idle(300); step(1, 0); step(2, 1); step(4, 2); // R12 after long idle

    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 1103515245 + 12345;
      if (((lcg >>> 16) & 3) == 0) step(0, 0);
      else step(((lcg >>> 18) & 7) % 6, (lcg >>> 22) & 3);
    end

    for (int k = 1; k <= 8; k++) begin
      checks++;
      if (seen[k] == 0) begin
        errors++;
        $display("FAIL %s code %0d occurrences actual 0 expected >0", rtag(k), k);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule